// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers asynchronous serial characters from a single line. It looks at the line once per pulse of a sample tick that runs at sixteen times the bit rate. A position counter splits every bit time into sixteen slots. The receiver waits for a line that has stayed high before it accepts a low sample as the start of a character. It then checks that start bit with three early samples. It decides each data bit by a two-of-three vote taken around the middle of the bit. The bit-rate generator that makes the tick is outside the block.

A character holds 8 or 9 data bits, chosen by a mode input, followed by one stop bit. When the last data bit has been voted, the byte moves to a holding register and a full flag rises. The full flag raises an interrupt request when the enable input allows it. A read strobe empties the holding register. A noise flag reports disagreeing samples and rejected start bits.

To follow a sender whose rate is slightly off, the position counter is realigned on the start edge. It is also realigned on every high-to-low edge that comes after a bit voted 1.

Top module: `osr_uart_rx`

## Requirements
- R1: Start search only happens on tick pulses. A low sample starts a character only when the three tick samples just before it were all high. A line that has been high for fewer than three samples since reset, or since a rejected start, does not start a character.
- R2: The start bit is checked at slot positions 3, 5 and 7, where position 1 is the first low sample. If all three are low, the character is accepted and no noise is charged to it. If exactly one of them is high, the character is accepted and its noise flag is set.
- R3: If two or three of the start check samples are high, the character is dropped. No transfer happens, `rx_full` keeps its value, `rx_noise` becomes 1, and the search starts again. That search needs three new high samples.
- R4: Each data bit takes the majority value of its samples at slot positions 8, 9 and 10.
- R5: If any data bit's three vote samples are not all equal, `rx_noise` is 1 after that character is transferred. A clean character leaves `rx_noise` at 0.
- R6: After a data bit votes 1, a high-to-low line edge makes that sample slot position 1 of the next bit. This applies to an edge in slots 11 to 16 of that bit or slots 1 to 7 of the following one. As a result, bit periods of 14 or 18 ticks in an alternating pattern still decode correctly.
- R7: `nine_bit` = 0 selects 8 data bits and `nine_bit` = 1 selects 9. Bits arrive least significant first, so the first data bit lands in `rx_data[0]`.
- R8: In 9-bit mode `ninth_bit` holds data bit 8. In 8-bit mode it repeats data bit 7.
- R9: When the last data bit is voted, the data moves to `rx_data` and `rx_full` becomes 1. `rx_irq` equals `rx_full` AND `rx_ie`.
- R10: A one-cycle `rd_strobe` clears `rx_full` and `rx_noise` on the next edge, which also drops `rx_irq`.
- R11: After reset, `rx_data`, `ninth_bit`, `rx_full`, `rx_noise` and `rx_irq` are all 0.
- R12: Internal state advances only on cycles where `sample_tick` is 1. Line activity while the tick is held low has no effect on the character being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line, idle high |
| sample_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Holding register read pulse |
| rx_data | output | 8 | Received data byte |
| ninth_bit | output | 1 | Ninth data bit, or a copy of bit 7 in 8-bit mode |
| rx_full | output | 1 | Holding register has an unread character |
| rx_noise | output | 1 | Noise seen on the last character or on a rejected start |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The case that is hardest to reach from the ports is realignment under rate mismatch. The counter must jump both backward (a late edge in slots 1 to 7) and forward (an early edge in slots 11 to 16, which also ends the current bit). The bench stretches every bit to 18 ticks, and separately shrinks every bit to 14 ticks. It uses an alternating data pattern, so each bit voted 1 is followed by an edge. Without realignment the later bits would be sampled inside their neighbours. A pause test stops the tick in the middle of a bit and wiggles the line, which shows that only tick cycles count.

// File: rtl/osr_pkg.sv
package osr_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  // two-of-three vote
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // number of high samples in a trio
  function automatic logic [1:0] ones3(input logic [2:0] s);
    return {1'b0, s[0]} + {1'b0, s[1]} + {1'b0, s[2]};
  endfunction

  // samples disagree
  function automatic logic split3(input logic [2:0] s);
    return (s != 3'b000) && (s != 3'b111);
  endfunction

endpackage

// File: rtl/osr_edge_finder.sv
module osr_edge_finder #(
  parameter int QUIET = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic hist_clr,
  output logic quiet_fall,
  output logic any_fall
);
  logic [QUIET-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (tick) begin
      if (hist_clr) hist <= '0;
      else          hist <= {hist[QUIET-2:0], rxd};
    end
  end

  // low sample after QUIET high samples
  assign quiet_fall = tick && (&hist) && !rxd;
  // low sample right after a high sample
  assign any_fall   = tick && hist[0] && !rxd;

endmodule

// File: rtl/osr_vote3.sv
module osr_vote3 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grab,
  input  logic       rxd,
  output logic [2:0] trio
);
  logic [1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cap <= '0;
    else if (grab) cap <= {cap[0], rxd};
  end

  // two held samples plus the live one
  assign trio = {cap, rxd};

endmodule

// File: rtl/osr_rx_fsm.sv
module osr_rx_fsm
  import osr_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int MAXB = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rxd,
  input  logic            nine_bit,
  input  logic            quiet_fall,
  input  logic            any_fall,
  output logic            hist_clr,
  output logic            xfer,
  output logic [MAXB-1:0] xfer_word,
  output logic            xfer_noise,
  output logic            reject
);
  localparam int RTW = $clog2(OSR + 1);
  localparam int BW  = $clog2(MAXB);
  localparam int MID = OSR / 2;
  localparam logic [RTW-1:0] RT_ONE = RTW'(1);
  localparam logic [RTW-1:0] RT_TWO = RTW'(2);
  localparam logic [RTW-1:0] RT_C3  = RTW'(MID - 5);
  localparam logic [RTW-1:0] RT_C5  = RTW'(MID - 3);
  localparam logic [RTW-1:0] RT_C7  = RTW'(MID - 1);
  localparam logic [RTW-1:0] RT_V8  = RTW'(MID);
  localparam logic [RTW-1:0] RT_V9  = RTW'(MID + 1);
  localparam logic [RTW-1:0] RT_V10 = RTW'(MID + 2);
  localparam logic [RTW-1:0] RT_END = RTW'(OSR);

  rx_state_e       state;
  logic [RTW-1:0]  rt;
  logic [BW-1:0]   bidx, last_idx;
  logic [MAXB-1:0] shreg, word_next;
  logic            armed, cnoise;
  logic            grab, chk_now, vote_now, stop_now, vbit;
  logic            slot_end, in_bits, late, resync;
  logic [2:0]      trio;
  logic [1:0]      n_ones;

  osr_vote3 u_vote (
    .clk  (clk),
    .rst_n(rst_n),
    .grab (grab),
    .rxd  (rxd),
    .trio (trio)
  );

  always_comb begin
    in_bits  = (state == ST_DATA) || (state == ST_STOP);
    last_idx = nine_bit ? BW'(MAXB - 1) : BW'(MAXB - 2);
    slot_end = (rt == RT_END);
    late     = (rt > RT_V10);
    grab     = tick && (((state == ST_START) && (rt == RT_C3 || rt == RT_C5)) ||
                        (in_bits && (rt == RT_V8 || rt == RT_V9)));
    chk_now  = tick && (state == ST_START) && (rt == RT_C7);
    vote_now = tick && (state == ST_DATA) && (rt == RT_V10);
    stop_now = tick && (state == ST_STOP) && (rt == RT_V10);
    n_ones   = ones3(trio);
    vbit     = maj3(trio);
    reject   = chk_now && (n_ones >= 2'd2);
    resync   = tick && armed && any_fall && in_bits && ((rt <= RT_C7) || late);
    word_next       = shreg;
    word_next[bidx] = vbit;
    xfer       = vote_now && (bidx == last_idx);
    xfer_word  = word_next;
    xfer_noise = cnoise | split3(trio);
    hist_clr   = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_HUNT;
      rt     <= '0;
      bidx   <= '0;
      shreg  <= '0;
      cnoise <= 1'b0;
    end else if (tick) begin
      unique case (state)
        ST_HUNT: begin
          if (quiet_fall) begin
            state  <= ST_START;
            rt     <= RT_TWO;
            cnoise <= 1'b0;
          end
        end
        ST_START: begin
          if (reject) begin
            state <= ST_HUNT;
          end else begin
            if (chk_now) cnoise <= (n_ones == 2'd1);
            if (slot_end) begin
              state <= ST_DATA;
              rt    <= RT_ONE;
              bidx  <= '0;
            end else begin
              rt <= rt + RT_ONE;
            end
          end
        end
        ST_DATA: begin
          if (vote_now) begin
            shreg  <= word_next;
            cnoise <= cnoise | split3(trio);
          end
          if (resync || slot_end) begin
            rt <= resync ? RT_TWO : RT_ONE;
            if (!resync || late) begin
              if (bidx == last_idx) state <= ST_STOP;
              else                  bidx  <= bidx + BW'(1);
            end
          end else begin
            rt <= rt + RT_ONE;
          end
        end
        ST_STOP: begin
          if (stop_now)    state <= ST_HUNT;
          else if (resync) rt    <= RT_TWO;
          else             rt    <= rt + RT_ONE;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // realignment window opens after a bit votes 1, closes at slot 7
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           armed <= 1'b0;
    else if (vote_now)                    armed <= vbit;
    else if (tick && (resync || rt == RT_C7 || state == ST_HUNT)) armed <= 1'b0;
  end

  // R1
  hunt_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT && quiet_fall) |=> (state == ST_START && rt == RT_TWO));

  // R3
  reject_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (state == ST_HUNT));

  // R6
  resync_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (rt == RT_TWO && (state == ST_DATA || state == ST_STOP)));

  // R12
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(rt) && $stable(state)));

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx #(
  parameter int OSR   = 16,
  parameter int MAXB  = 9,
  parameter int QUIET = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rxd,
  input  logic            sample_tick,
  input  logic            nine_bit,
  input  logic            rx_ie,
  input  logic            rd_strobe,
  output logic [MAXB-2:0] rx_data,
  output logic            ninth_bit,
  output logic            rx_full,
  output logic            rx_noise,
  output logic            rx_irq
);
  localparam int DW = MAXB - 1;

  logic            quiet_fall, any_fall, hist_clr;
  logic            xfer, xfer_noise, reject;
  logic [MAXB-1:0] xfer_word;

  osr_edge_finder #(.QUIET(QUIET)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_tick),
    .rxd       (rxd),
    .hist_clr  (hist_clr),
    .quiet_fall(quiet_fall),
    .any_fall  (any_fall)
  );

  osr_rx_fsm #(.OSR(OSR), .MAXB(MAXB)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_tick),
    .rxd       (rxd),
    .nine_bit  (nine_bit),
    .quiet_fall(quiet_fall),
    .any_fall  (any_fall),
    .hist_clr  (hist_clr),
    .xfer      (xfer),
    .xfer_word (xfer_word),
    .xfer_noise(xfer_noise),
    .reject    (reject)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      ninth_bit <= 1'b0;
      rx_full   <= 1'b0;
      rx_noise  <= 1'b0;
    end else if (xfer) begin
      rx_data   <= xfer_word[DW-1:0];
      ninth_bit <= nine_bit ? xfer_word[MAXB-1] : xfer_word[MAXB-2];
      rx_full   <= 1'b1;
      rx_noise  <= xfer_noise;
    end else begin
      if (rd_strobe) rx_full <= 1'b0;
      if (reject)         rx_noise <= 1'b1;
      else if (rd_strobe) rx_noise <= 1'b0;
    end
  end

  assign rx_irq = rx_full & rx_ie;

  // R9
  full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(xfer));

  // R10
  read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !xfer) |=> !rx_full);

endmodule

// File: tb/osr_uart_rx_tb.sv
`timescale 1ns/1ps
module osr_uart_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b0;
  logic       tick = 1'b0;
  logic       tick_run = 1'b1;
  logic       nine = 1'b0;
  logic       rie = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] data;
  logic       r8, full, noise, irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) tick <= tick_run ? ~tick : 1'b0;

  osr_uart_rx dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxd        (rxd),
    .sample_tick(tick),
    .nine_bit   (nine),
    .rx_ie      (rie),
    .rd_strobe  (rd),
    .rx_data    (data),
    .ninth_bit  (r8),
    .rx_full    (full),
    .rx_noise   (noise),
    .rx_irq     (irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive the line and count n tick samples
  task automatic hold(input logic v, input int n);
    @(negedge clk);
    rxd = v;
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  task automatic put_bit(input logic v, input int blen, input bit glitch, input int gpos);
    if (glitch) begin
      hold(v, gpos - 1);
      hold(!v, 1);
      hold(v, blen - gpos);
    end else begin
      hold(v, blen);
    end
  endtask

  // stop the tick and wiggle the line
  task automatic pause_garbage(input logic v);
    tick_run = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rxd = i[0] ^ i[2];
    end
    @(negedge clk);
    rxd = v;
    @(posedge clk);
    tick_run = 1'b1;
  endtask

  // gbit: -1 start bit, 0..8 data bit, 100 none; pbit: data bit to pause in
  task automatic send_frame(input logic [8:0] d, input int nb, input int blen,
                            input int gbit, input int gpos, input int pbit);
    hold(1'b1, 24);
    put_bit(1'b0, blen, gbit == -1, gpos);
    for (int i = 0; i < nb; i++) begin
      if (i == pbit) begin
        hold(d[i], blen / 2);
        pause_garbage(d[i]);
        hold(d[i], blen - blen / 2);
      end else begin
        put_bit(d[i], blen, gbit == i, gpos);
      end
    end
    hold(1'b1, blen);
    hold(1'b1, 8);
    @(negedge clk);
  endtask

  task automatic expect_char(input string req, input logic [7:0] ed,
                             input logic er8, input logic en);
    chk(req, "rx_full", {15'd0, full}, 16'd1);
    chk(req, "rx_data", {8'd0, data}, {8'd0, ed});
    chk(req, "ninth_bit", {15'd0, r8}, {15'd0, er8});
    chk(req, "rx_noise", {15'd0, noise}, {15'd0, en});
  endtask

  task automatic read_buf();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R10", "rx_full after read", {15'd0, full}, 16'd0);
    chk("R10", "rx_irq after read", {15'd0, irq}, 16'd0);
    chk("R10", "rx_noise after read", {15'd0, noise}, 16'd0);
  endtask

  task automatic t_reset();
    chk("R11", "rx_data", {8'd0, data}, 16'd0);
    chk("R11", "ninth_bit", {15'd0, r8}, 16'd0);
    chk("R11", "rx_full", {15'd0, full}, 16'd0);
    chk("R11", "rx_noise", {15'd0, noise}, 16'd0);
    chk("R11", "rx_irq", {15'd0, irq}, 16'd0);
  endtask

  // line low from reset, only two high samples before a long low
  task automatic t_no_quiet();
    hold(1'b0, 40);
    hold(1'b1, 2);
    hold(1'b0, 200);
    hold(1'b1, 40);
    @(negedge clk);
    chk("R1", "no start without three highs: rx_full", {15'd0, full}, 16'd0);
    chk("R1", "no start without three highs: rx_noise", {15'd0, noise}, 16'd0);
  endtask

  task automatic t_clean();
    nine = 1'b0;
    rie  = 1'b0;
    send_frame(9'h0A5, 8, 16, 100, 0, 100);
    expect_char("R7", 8'hA5, 1'b1, 1'b0);
    chk("R2", "clean start gives no noise", {15'd0, noise}, 16'd0);
    chk("R9", "rx_irq masked", {15'd0, irq}, 16'd0);
    @(negedge clk);
    rie = 1'b1;
    #1;
    chk("R9", "rx_irq enabled", {15'd0, irq}, 16'd1);
    read_buf();
  endtask

  task automatic t_ninth();
    nine = 1'b1;
    send_frame(9'h0C3, 9, 16, 100, 0, 100);
    expect_char("R8", 8'hC3, 1'b0, 1'b0);
    read_buf();
    send_frame(9'h123, 9, 16, 100, 0, 100);
    expect_char("R8", 8'h23, 1'b1, 1'b0);
    read_buf();
    nine = 1'b0;
    send_frame(9'h035, 8, 16, 100, 0, 100);
    expect_char("R8", 8'h35, 1'b0, 1'b0);
    read_buf();
  endtask

  task automatic t_start_noise();
    send_frame(9'h05A, 8, 16, -1, 5, 100);
    expect_char("R2", 8'h5A, 1'b0, 1'b1);
    read_buf();
  endtask

  task automatic t_reject();
    hold(1'b1, 24);
    hold(1'b0, 3);
    hold(1'b1, 40);
    @(negedge clk);
    chk("R3", "rejected start: rx_full", {15'd0, full}, 16'd0);
    chk("R3", "rejected start: rx_noise", {15'd0, noise}, 16'd1);
    send_frame(9'h03C, 8, 16, 100, 0, 100);
    expect_char("R3", 8'h3C, 1'b0, 1'b0);
    read_buf();
  endtask

  task automatic t_majority();
    send_frame(9'h0FF, 8, 16, 2, 8, 100);
    expect_char("R4", 8'hFF, 1'b1, 1'b1);
    read_buf();
    send_frame(9'h000, 8, 16, 3, 9, 100);
    expect_char("R5", 8'h00, 1'b0, 1'b1);
    read_buf();
  endtask

  task automatic t_drift();
    nine = 1'b1;
    send_frame(9'h155, 9, 18, 100, 0, 100);
    expect_char("R6", 8'h55, 1'b1, 1'b0);
    read_buf();
    send_frame(9'h155, 9, 14, 100, 0, 100);
    expect_char("R6", 8'h55, 1'b1, 1'b0);
    read_buf();
    nine = 1'b0;
    send_frame(9'h055, 8, 14, 100, 0, 100);
    expect_char("R6", 8'h55, 1'b0, 1'b0);
    read_buf();
  endtask

  task automatic t_tick_pause();
    nine = 1'b0;
    send_frame(9'h096, 8, 16, 100, 0, 3);
    expect_char("R12", 8'h96, 1'b1, 1'b0);
    read_buf();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_quiet();
    t_clean();
    t_ninth();
    t_start_noise();
    t_reject();
    t_majority();
    t_drift();
    t_tick_pause();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1-R12 run: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule